// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block decides which of several interrupt causes the CPU should serve next. There are eight maskable sources, one non-maskable input and one software trap. Each maskable source has a 3-bit code from 0 to 7. Software decides which code sits at each of eight priority levels by writing a 24-bit table through three byte-wide configuration registers. A mask byte gates each source. A global-disable input blocks every source except the trap.

Requests are latched as pending. The controller shows the winning request to the CPU as a code plus a valid strobe. When the CPU acknowledges, that request moves from pending to in-service. A request is shown only if its level is strictly above every level already in service, so a higher level can preempt a routine that is running. An end-of-service pulse retires the highest in-service level, so nested routines unwind in order.

Software can also drop the pending request of a given source with a clear command. The command does nothing while that source is in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_valid` is low and the mask byte is 00h, so all eight maskable sources are masked. The priority table resets to the identity mapping, in which level k holds code k.
- R2: Writing address 0 sets the mask byte. Bit i = 1 enables source i. A request from a masked source stays pending and is presented as soon as its bit is set.
- R3: Addresses 2, 3 and 4 write bits 7:0, 15:8 and 23:16 of the priority table. Bits 3k+2..3k hold the code of the source at level k. Level 7 is the highest configurable level and level 0 the lowest.
- R4: With nothing in service, the presented code (0 to 7) is the enabled pending source that sits at the highest level.
- R5: A request is presented only when its level is above the highest in-service level. When `irq_ack` is high while `irq_valid` is high, the presented request is cleared from pending and marked in service. `eoi` retires the highest in-service level.
- R6: The non-maskable request is presented as code 8. It sits at a level above all configurable levels, ignores the mask and is blocked by `gdis`.
- R7: The trap is presented as code 9 at the top level, even while `gdis` is high. While the trap is in service, nothing else is presented, including a new trap.
- R8: While `gdis` is high, no maskable source is presented. Its pending state is kept.
- R9: When `clr_en` is high, the pending request of source `clr_code` is removed, unless that source is in service; in that case the command has no effect.
- R10: `irq_code` reads 0 whenever `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address (0 mask, 2/3/4 priority table bytes) |
| cfg_wdata | input | 8 | Configuration write data |
| src_irq | input | 8 | Request from maskable source i, sampled high to set pending |
| nmi_in | input | 1 | Non-maskable request, sampled high to set pending |
| trap_in | input | 1 | Software trap request, sampled high to set pending |
| gdis | input | 1 | Global disable for all requests except the trap |
| clr_en | input | 1 | Clear-pending command strobe |
| clr_code | input | 3 | Source code targeted by the clear command |
| irq_ack | input | 1 | CPU accepts the presented request |
| eoi | input | 1 | CPU finished the innermost routine |
| irq_valid | output | 1 | A request is being presented |
| irq_code | output | 4 | Presented code: 0-7 sources, 8 non-maskable, 9 trap |

## Verification
Some rules are checked on every cycle:
- the presented code stays in range and reads 0 when idle;
- no masked source is ever presented;
- global disable hides everything except the trap;
- a pending trap outside service is always shown;
- every acknowledge adds exactly one in-service level.

Other rules need whole scenarios from the bench:
- which source wins under a given mapping and mask;
- whether nesting unwinds in the right order;
- that pending requests survive masking;
- that a clear aimed at a source in service leaves its pending request in place.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter logic [23:0] PRIO_RESET = 24'hFAC688,
  parameter logic [7:0]  MASK_RESET = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic [7:0] src_irq,
  input  logic       nmi_in,
  input  logic       trap_in,
  input  logic       gdis,
  input  logic       clr_en,
  input  logic [2:0] clr_code,
  input  logic       irq_ack,
  input  logic       eoi,
  output logic       irq_valid,
  output logic [3:0] irq_code
);
  localparam int NSRC = 8;
  localparam int NLVL = NSRC + 2;
  localparam logic [3:0] LVL_NMI  = 4'd8;
  localparam logic [3:0] LVL_TRAP = 4'd9;

  logic [7:0]      mask_q, pend_q;
  logic [23:0]     prio_q;
  logic            nmi_pend_q, trap_pend_q;
  logic [NLVL-1:0] isr_q;

  logic [7:0] elig, src_svc, ack_clr, cmd_clr;
  logic       svc_any, cand_ok, sel_ok, take;
  logic [3:0] top_lvl, sel_lvl, sel_code;
  logic [2:0] cand_lvl, cand_src;
  logic [NLVL-1:0] pop_mask, push_mask;

  assign elig = pend_q & mask_q & {NSRC{~gdis}};

  always_comb begin
    svc_any = 1'b0;
    top_lvl = 4'd0;
    for (int l = 0; l < NLVL; l++)
      if (isr_q[l]) begin
        svc_any = 1'b1;
        top_lvl = 4'(l);
      end
  end

  always_comb begin
    cand_ok  = 1'b0;
    cand_lvl = 3'd0;
    cand_src = 3'd0;
    src_svc  = 8'd0;
    for (int l = 0; l < NSRC; l++) begin
      if (elig[prio_q[3*l +: 3]]) begin
        cand_ok  = 1'b1;
        cand_lvl = 3'(l);
        cand_src = prio_q[3*l +: 3];
      end
      if (isr_q[l]) src_svc[prio_q[3*l +: 3]] = 1'b1;
    end
  end

  always_comb begin
    sel_ok   = 1'b0;
    sel_lvl  = 4'd0;
    sel_code = 4'd0;
    if (trap_pend_q && !isr_q[LVL_TRAP]) begin
      sel_ok   = 1'b1;
      sel_lvl  = LVL_TRAP;
      sel_code = 4'd9;
    end else if (nmi_pend_q && !gdis && (!svc_any || top_lvl < LVL_NMI)) begin
      sel_ok   = 1'b1;
      sel_lvl  = LVL_NMI;
      sel_code = 4'd8;
    end else if (cand_ok && (!svc_any || {1'b0, cand_lvl} > top_lvl)) begin
      sel_ok   = 1'b1;
      sel_lvl  = {1'b0, cand_lvl};
      sel_code = {1'b0, cand_src};
    end
  end

  assign irq_valid = sel_ok;
  assign irq_code  = sel_code;
  assign take      = sel_ok & irq_ack;
  assign ack_clr   = (take && !sel_lvl[3]) ? (8'b1 << sel_code[2:0]) : 8'b0;
  assign cmd_clr   = (clr_en && !src_svc[clr_code]) ? (8'b1 << clr_code) : 8'b0;
  assign pop_mask  = (eoi && svc_any) ? (NLVL'(1) << top_lvl) : '0;
  assign push_mask = take ? (NLVL'(1) << sel_lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q      <= MASK_RESET;
      prio_q      <= PRIO_RESET;
      pend_q      <= 8'd0;
      nmi_pend_q  <= 1'b0;
      trap_pend_q <= 1'b0;
      isr_q       <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          3'd0:    mask_q         <= cfg_wdata;
          3'd2:    prio_q[7:0]    <= cfg_wdata;
          3'd3:    prio_q[15:8]   <= cfg_wdata;
          3'd4:    prio_q[23:16]  <= cfg_wdata;
          default: ;
        endcase
      end
      pend_q      <= (pend_q & ~ack_clr & ~cmd_clr) | src_irq;
      nmi_pend_q  <= (nmi_pend_q & ~(take && sel_lvl == LVL_NMI)) | nmi_in;
      trap_pend_q <= (trap_pend_q & ~(take && sel_lvl == LVL_TRAP)) | trap_in;
      isr_q       <= (isr_q & ~pop_mask) | push_mask;
    end
  end

  assert_code_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_code <= 4'd9);

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> irq_code == 4'd0);

  assert_mask_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_code < 4'd8) |-> mask_q[irq_code[2:0]]);

  assert_gdis_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gdis && !trap_pend_q) |-> !irq_valid);

  assert_trap_shown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pend_q && !isr_q[LVL_TRAP]) |-> (irq_valid && irq_code == 4'd9));

  assert_ack_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack && !eoi) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [7:0] src_irq = 8'd0;
  logic nmi_in = 1'b0, trap_in = 1'b0, gdis = 1'b0;
  logic clr_en = 1'b0;
  logic [2:0] clr_code = 3'd0;
  logic irq_ack = 1'b0, eoi = 1'b0;
  logic irq_valid;
  logic [3:0] irq_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .src_irq(src_irq), .nmi_in(nmi_in),
    .trap_in(trap_in), .gdis(gdis), .clr_en(clr_en), .clr_code(clr_code),
    .irq_ack(irq_ack), .eoi(eoi), .irq_valid(irq_valid), .irq_code(irq_code)
  );

  // mask[21:14] src[13:6] gdis[5] exp_valid[4] exp_code[3:0]
  localparam logic [21:0] VEC [0:7] = '{
    {8'hFF, 8'h01, 1'b0, 1'b1, 4'd0},
    {8'hFF, 8'h81, 1'b0, 1'b1, 4'd7},
    {8'h7F, 8'h81, 1'b0, 1'b1, 4'd0},
    {8'h00, 8'hFF, 1'b0, 1'b0, 4'd0},
    {8'hFF, 8'h24, 1'b0, 1'b1, 4'd5},
    {8'hFF, 8'hFF, 1'b1, 1'b0, 4'd0},
    {8'hF0, 8'h0F, 1'b0, 1'b0, 4'd0},
    {8'h0F, 8'h3C, 1'b0, 1'b1, 4'd3}
  };

  task automatic check(input bit ev, input logic [3:0] ec, input string req);
    n_chk++;
    if (irq_valid !== ev || irq_code !== ec) begin
      n_bad++;
      $display("FAIL %s: valid=%0b code=%0d expected valid=%0b code=%0d",
               req, irq_valid, irq_code, ev, ec);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_src(input logic [7:0] v);
    src_irq = v;
    tick();
    src_irq = 8'd0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic end_svc();
    eoi = 1'b1;
    tick();
    eoi = 1'b0;
  endtask

  task automatic clr(input logic [2:0] c);
    clr_en = 1'b1; clr_code = c;
    tick();
    clr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: valid=%0b code=%0d expected completion", irq_valid, irq_code);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check(1'b0, 4'd0, "R1 R10");
    rst_n = 1'b1;
    tick();
    check(1'b0, 4'd0, "R1");
    pulse_src(8'hFF);
    check(1'b0, 4'd0, "R1 mask reset");
    wr(3'd0, 8'hFF);
    check(1'b1, 4'd7, "R1 identity R2");
    for (int c = 0; c < 8; c++) clr(3'(c));
    check(1'b0, 4'd0, "R9");

    for (int i = 0; i < 8; i++) begin
      wr(3'd0, VEC[i][21:14]);
      gdis = VEC[i][5];
      pulse_src(VEC[i][13:6]);
      check(VEC[i][4], VEC[i][3:0], "R4 R2 R8");
      gdis = 1'b0;
      for (int c = 0; c < 8; c++) clr(3'(c));
      check(1'b0, 4'd0, "R9 after vector");
    end

    // R3: swap levels 0 and 7
    wr(3'd0, 8'hFF);
    wr(3'd2, 8'h8F); wr(3'd3, 8'hC6); wr(3'd4, 8'h1A);
    pulse_src(8'h81);
    check(1'b1, 4'd0, "R3");
    clr(3'd0);
    check(1'b1, 4'd7, "R3");
    clr(3'd7);
    check(1'b0, 4'd0, "R9");
    wr(3'd2, 8'h88); wr(3'd3, 8'hC6); wr(3'd4, 8'hFA);

    // R5 nesting
    pulse_src(8'h08);  check(1'b1, 4'd3, "R5");
    ack();             check(1'b0, 4'd0, "R5 acked");
    pulse_src(8'h02);  check(1'b0, 4'd0, "R5 lower blocked");
    pulse_src(8'h20);  check(1'b1, 4'd5, "R5 preempt");
    ack();             check(1'b0, 4'd0, "R5");
    end_svc();         check(1'b0, 4'd0, "R5 level 3 still active");
    end_svc();         check(1'b1, 4'd1, "R5 unwind");
    ack();             check(1'b0, 4'd0, "R5");
    end_svc();         check(1'b0, 4'd0, "R5 empty");

    // R6 and R7
    pulse_src(8'h80);  check(1'b1, 4'd7, "R4");
    nmi_in = 1'b1; tick(); nmi_in = 1'b0;
    check(1'b1, 4'd8, "R6 above sources");
    gdis = 1'b1; tick();
    check(1'b0, 4'd0, "R6 gdis blocks");
    gdis = 1'b0; tick();
    ack();             check(1'b0, 4'd0, "R6 nmi in service");
    trap_in = 1'b1; tick(); trap_in = 1'b0;
    check(1'b1, 4'd9, "R7 over nmi");
    gdis = 1'b1; tick();
    check(1'b1, 4'd9, "R7 ignores gdis");
    ack();             check(1'b0, 4'd0, "R7 in service");
    trap_in = 1'b1; tick(); trap_in = 1'b0;
    check(1'b0, 4'd0, "R7 no preempt");
    end_svc();         check(1'b1, 4'd9, "R7 pending again");
    ack();
    end_svc();         check(1'b0, 4'd0, "R8 gdis");
    gdis = 1'b0; tick();
    check(1'b0, 4'd0, "R6 nmi still in service");
    end_svc();         check(1'b1, 4'd7, "R6 unwind");
    clr(3'd7);         check(1'b0, 4'd0, "R9");

    // R9 clear while in service
    pulse_src(8'h10);  check(1'b1, 4'd4, "R9");
    ack();             check(1'b0, 4'd0, "R9");
    pulse_src(8'h10);  check(1'b0, 4'd0, "R9");
    clr(3'd4);         check(1'b0, 4'd0, "R9");
    end_svc();         check(1'b1, 4'd4, "R9 clear ignored in service");
    ack();
    end_svc();         check(1'b0, 4'd0, "R9");
    pulse_src(8'h40);  check(1'b1, 4'd6, "R4");
    clr(3'd6);         check(1'b0, 4'd0, "R9 clear removes");

    // R2 pending kept under mask
    wr(3'd0, 8'h00);
    pulse_src(8'h04);  check(1'b0, 4'd0, "R2 masked");
    wr(3'd0, 8'h04);   check(1'b1, 4'd2, "R2 unmask presents");
    clr(3'd2);         check(1'b0, 4'd0, "R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule